// File: doc/BRIEF.md
# Page Write Load Controller

This block sits in front of a byte-wide nonvolatile store. It watches three active-low strobes (chip enable, write enable, output enable) and turns each accepted write pulse into a byte load. The load goes into a staging buffer that holds one page of 32 bytes. The strobes arrive already synchronised to the clock. Loads may come in any order within the page. Nothing marks the end of a sequence. Instead, a quiet-time window runs after each accepted pulse, and when it runs out with no new strobe, a self-timed program cycle starts. That cycle copies only the staged bytes into the internal storage array and leaves every other byte of the page as it was.

All timing is counted in clock cycles: the quiet window, the program duration and the shortest pulse that counts as a write. While the program cycle runs, the block raises `busy` and ignores any strobe activity. It also exposes the address and data of the most recent accepted load for neighbouring status logic. A plain read path returns a stored byte on `dout`.

Top module: `page_write_ctrl`

## Requirements
- R1: A pulse counts as a write only while `ce_n`=0, `we_n`=0 and `oe_n`=1. If `oe_n` goes low while both strobes are still low, the pulse is dropped with no effect.
- R2: The address is sampled in the first cycle the write condition holds, which is the later of the two strobe falls. The data is sampled in the cycle the condition ends, which is the earlier of the two strobe rises. Both `we_n`-driven and `ce_n`-driven pulses work.
- R3: `addr[4:0]` selects the byte slot in the 32-entry buffer, and slots may be loaded in any order. The page that gets programmed is `addr[ADDR_W-1:5]` of the last accepted load.
- R4: `busy` rises exactly LOAD_WIN cycles after the cycle in which the last accepted pulse ended. Any strobe activity inside that window holds the window off, and each accepted pulse restarts it.
- R5: `busy` stays high for exactly PROG_CYC cycles. The array holds the new bytes once `busy` has fallen.
- R6: Programming writes only the slots loaded in the current sequence. If a slot is loaded twice, the later byte wins. Unloaded bytes of the page keep their old contents.
- R7: A pulse that holds the write condition for fewer than MIN_LOW sampled cycles loads nothing and does not start a window.
- R8: Any pulse whose write condition begins while `busy` is high is ignored, even if it ends after `busy` falls. Slot flags clear when programming ends, so the next sequence writes only its own bytes.
- R9: `last_addr` and `last_data` take the address and data of each accepted load, and they do not change while `busy` is high.
- R10: With `ce_n`=0, `oe_n`=0 and `we_n`=1, `dout` shows `array[addr]` one cycle later. When the read condition is not met, `dout` keeps its value.
- R11: After reset, `busy`, `dout`, `last_addr` and `last_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip enable, active low, synchronised |
| we_n | input | 1 | Write enable, active low, synchronised |
| oe_n | input | 1 | Output enable, active low, synchronised |
| addr | input | ADDR_W | Byte address; the low 5 bits select the slot |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, registered |
| busy | output | 1 | High while the program cycle runs |
| last_addr | output | ADDR_W | Address of the most recent accepted load |
| last_data | output | DATA_W | Data of the most recent accepted load |

## Verification
The assertions assume the strobes are clean synchronous levels. They also assume `addr` is valid in the cycle the write condition begins and `din` is valid in the cycle it ends. The pulse-width and window checks count whole sampled cycles, so the stimulus changes every input at the falling clock edge and keeps each pulse and gap an exact number of cycles long. In the chip-enable-driven case, the bench changes the address and data between strobe edges on purpose, to show which cycle each is taken in. Everywhere else it holds them constant across the pulse.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PROG = 2'd2
    } phase_e;

    // Width of a counter that must hold the value n.
    function automatic int cnt_bits(input int n);
        if (n < 2) return 1;
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/pwc_strobe.sv
module pwc_strobe
    import pwc_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int MIN_LOW = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              hold_off,
    output logic              act,
    output logic              ld_evt,
    output logic [ADDR_W-1:0] cap_addr
);
    localparam int              LEN_W   = cnt_bits(MIN_LOW);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MIN_LOW);

    logic             act_q;
    logic             cap_ok;
    logic [LEN_W-1:0] len;
    logic             strobe_up;

    // Write condition: both strobes low, output enable high.
    assign act       = ~ce_n & ~we_n & oe_n;
    // The pulse must end through a strobe rising, not through oe_n falling.
    assign strobe_up = ce_n | we_n;
    assign ld_evt    = act_q & ~act & cap_ok & strobe_up & (len >= LEN_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q    <= 1'b0;
            cap_ok   <= 1'b0;
            len      <= '0;
            cap_addr <= '0;
        end else begin
            act_q <= act;
            if (act && !act_q) begin
                cap_addr <= addr;
                len      <= LEN_W'(1);
                cap_ok   <= ~hold_off;
            end else if (act && (len != LEN_MAX)) begin
                len <= len + LEN_W'(1);
            end
        end
    end

endmodule

// File: rtl/pwc_sequencer.sv
module pwc_sequencer
    import pwc_pkg::*;
#(
    parameter int LOAD_WIN = 16,
    parameter int PROG_CYC = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic ld_evt,
    input  logic act,
    output logic busy,
    output logic commit
);
    localparam int             TW     = cnt_bits(LOAD_WIN);
    localparam int             PW     = cnt_bits(PROG_CYC);
    localparam logic [TW-1:0]  T_LAST = TW'(LOAD_WIN - 1);
    localparam logic [PW-1:0]  P_LAST = PW'(PROG_CYC - 1);

    phase_e         phase;
    logic [TW-1:0]  tmr;
    logic [PW-1:0]  pc;

    assign busy   = (phase == PH_PROG);
    assign commit = (phase == PH_PROG) && (pc == P_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            tmr   <= '0;
            pc    <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (ld_evt) begin
                        phase <= PH_LOAD;
                        tmr   <= '0;
                    end
                end
                PH_LOAD: begin
                    if (ld_evt) begin
                        tmr <= '0;
                    end else if (!act) begin
                        if (tmr == T_LAST) begin
                            phase <= PH_PROG;
                            pc    <= '0;
                        end else begin
                            tmr <= tmr + TW'(1);
                        end
                    end
                end
                PH_PROG: begin
                    if (pc == P_LAST) phase <= PH_IDLE;
                    else              pc    <= pc + PW'(1);
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pwc_page_buf.sv
module pwc_page_buf #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int OFS_W  = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ld_evt,
    input  logic                     commit,
    input  logic [ADDR_W-1:0]        cap_addr,
    input  logic [DATA_W-1:0]        din,
    output logic [DATA_W-1:0]        slot_q [1<<OFS_W],
    output logic [(1<<OFS_W)-1:0]    slot_vld,
    output logic [ADDR_W-OFS_W-1:0]  page
);
    localparam int NSLOT = 1 << OFS_W;

    logic [OFS_W-1:0] off;
    assign off = cap_addr[OFS_W-1:0];

    always_ff @(posedge clk) begin
        if (rst)         page <= '0;
        else if (ld_evt) page <= cap_addr[ADDR_W-1:OFS_W];
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic [DATA_W-1:0] q;
        logic              v;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
                v <= 1'b0;
            end else if (ld_evt && (off == OFS_W'(g))) begin
                q <= din;
                v <= 1'b1;
            end else if (commit) begin
                v <= 1'b0;
            end
        end
        assign slot_q[g]   = q;
        assign slot_vld[g] = v;
    end

endmodule

// File: rtl/pwc_array.sv
module pwc_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int OFS_W  = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     commit,
    input  logic [ADDR_W-OFS_W-1:0]  page,
    input  logic [DATA_W-1:0]        slot_q [1<<OFS_W],
    input  logic [(1<<OFS_W)-1:0]    slot_vld,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        dout
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int NSLOT = 1 << OFS_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Every flagged slot lands in the array in one cycle.
    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < NSLOT; i++) begin
                if (slot_vld[i]) mem[{page, OFS_W'(i)}] <= slot_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        dout <= '0;
        else if (rd_en) dout <= mem[rd_addr];
    end

endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl #(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 8,
    parameter int OFS_W    = 5,
    parameter int LOAD_WIN = 16,
    parameter int PROG_CYC = 50,
    parameter int MIN_LOW  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              busy,
    output logic [ADDR_W-1:0] last_addr,
    output logic [DATA_W-1:0] last_data
);
    localparam int NSLOT = 1 << OFS_W;
    localparam int PG_W  = ADDR_W - OFS_W;

    logic              act;
    logic              ld_evt;
    logic              commit;
    logic              rd_en;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] slot_q [NSLOT];
    logic [NSLOT-1:0]  slot_vld;
    logic [PG_W-1:0]   page;

    assign rd_en = ~ce_n & ~oe_n & we_n;

    pwc_strobe #(
        .ADDR_W  (ADDR_W),
        .MIN_LOW (MIN_LOW)
    ) u_strobe (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .addr     (addr),
        .hold_off (busy),
        .act      (act),
        .ld_evt   (ld_evt),
        .cap_addr (cap_addr)
    );

    pwc_sequencer #(
        .LOAD_WIN (LOAD_WIN),
        .PROG_CYC (PROG_CYC)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .ld_evt (ld_evt),
        .act    (act),
        .busy   (busy),
        .commit (commit)
    );

    pwc_page_buf #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) u_buf (
        .clk      (clk),
        .rst      (rst),
        .ld_evt   (ld_evt),
        .commit   (commit),
        .cap_addr (cap_addr),
        .din      (din),
        .slot_q   (slot_q),
        .slot_vld (slot_vld),
        .page     (page)
    );

    pwc_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) u_array (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .page     (page),
        .slot_q   (slot_q),
        .slot_vld (slot_vld),
        .rd_en    (rd_en),
        .rd_addr  (addr),
        .dout     (dout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            last_addr <= '0;
            last_data <= '0;
        end else if (ld_evt) begin
            last_addr <= cap_addr;
            last_data <= din;
        end
    end

endmodule

// File: rtl/pwc_checker.sv
module pwc_checker
    import pwc_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 8,
    parameter int LOAD_WIN = 16,
    parameter int PROG_CYC = 50,
    parameter int MIN_LOW  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              busy,
    input logic              ld_evt,
    input logic [ADDR_W-1:0] last_addr,
    input logic [DATA_W-1:0] last_data
);
    localparam int RW = cnt_bits(MIN_LOW);
    localparam int GW = cnt_bits(LOAD_WIN);
    localparam int BW = cnt_bits(PROG_CYC + 1);

    logic [RW-1:0] act_run;
    logic [GW-1:0] gap;
    logic [BW-1:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_run  <= '0;
            gap      <= '0;
            busy_run <= '0;
        end else begin
            if (~ce_n & ~we_n & oe_n) begin
                if (act_run != RW'(MIN_LOW)) act_run <= act_run + RW'(1);
            end else begin
                act_run <= '0;
            end
            if (ld_evt)                   gap <= '0;
            else if (gap != GW'(LOAD_WIN)) gap <= gap + GW'(1);
            if (busy) begin
                if (busy_run != BW'(PROG_CYC + 1)) busy_run <= busy_run + BW'(1);
            end else begin
                busy_run <= '0;
            end
        end
    end

    assert_strobe_end_R1: assert property (@(posedge clk) disable iff (rst)
        ld_evt |-> ($past(oe_n) && (ce_n || we_n)));

    assert_min_width_R7: assert property (@(posedge clk) disable iff (rst)
        ld_evt |-> (act_run >= RW'(MIN_LOW)));

    assert_window_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (gap == GW'(LOAD_WIN)));

    assert_prog_len_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_run == BW'(PROG_CYC)));

    assert_busy_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !ld_evt);

    assert_last_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(last_addr) && $stable(last_data)));

endmodule

bind page_write_ctrl pwc_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .LOAD_WIN (LOAD_WIN),
    .PROG_CYC (PROG_CYC),
    .MIN_LOW  (MIN_LOW)
) u_pwc_checker (
    .clk       (clk),
    .rst       (rst),
    .ce_n      (ce_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .busy      (busy),
    .ld_evt    (ld_evt),
    .last_addr (last_addr),
    .last_data (last_data)
);

// File: tb/tb_page_write_ctrl.sv
module tb_page_write_ctrl;
    localparam int AW = 10;
    localparam int DW = 8;
    localparam int OW = 5;
    localparam int LW = 16;
    localparam int PC = 50;
    localparam int ML = 2;
    localparam int NS = 1 << OW;
    localparam int PGW = AW - OW;

    // Stimulus table: {slot offset[12:8], data[7:0]} loaded into page 3, scrambled order.
    localparam logic [12:0] VEC [10] = '{
        {5'd17, 8'h3E}, {5'd2, 8'h81}, {5'd30, 8'hC4}, {5'd9, 8'h05}, {5'd2, 8'h6D},
        {5'd0, 8'hF0}, {5'd25, 8'h1B}, {5'd12, 8'hA7}, {5'd31, 8'h58}, {5'd6, 8'h92}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          ce_n, we_n, oe_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          busy;
    logic [AW-1:0] last_addr;
    logic [DW-1:0] last_data;

    always #5 clk = ~clk;

    page_write_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .OFS_W(OW),
        .LOAD_WIN(LW), .PROG_CYC(PC), .MIN_LOW(ML)
    ) dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .busy(busy),
        .last_addr(last_addr), .last_data(last_data)
    );

    int vectors = 0;
    int fails   = 0;

    logic [DW-1:0]  mdl [1<<AW];
    logic [DW-1:0]  pd  [NS];
    logic           pv  [NS];
    logic [PGW-1:0] pp;

    task automatic chk(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
        vectors++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
        end
    endtask

    function automatic logic [AW-1:0] mk(input int pg, input int off);
        return {PGW'(pg), OW'(off)};
    endfunction

    task automatic pulse_we(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input int n, input bit acc);
        @(negedge clk);
        addr = a; din = d; we_n = 1'b0;
        repeat (n) @(negedge clk);
        we_n = 1'b1;
        if (acc) begin
            pd[a[OW-1:0]] = d;
            pv[a[OW-1:0]] = 1'b1;
            pp = a[AW-1:OW];
        end
    endtask

    task automatic apply_prog();
        for (int i = 0; i < NS; i++) begin
            if (pv[i]) mdl[{pp, OW'(i)}] = pd[i];
            pv[i] = 1'b0;
        end
    endtask

    task automatic settle();
        repeat (LW + PC + 4) @(negedge clk);
        apply_prog();
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        addr = a; oe_n = 1'b0;
        @(negedge clk);
        d = dout; oe_n = 1'b1;
    endtask

    task automatic verify_page(input int pg, input string tag);
        logic [DW-1:0] v;
        for (int i = 0; i < NS; i++) begin
            rd(mk(pg, i), v);
            chk(tag, {24'd0, v}, {24'd0, mdl[mk(pg, i)]});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        logic [DW-1:0] keep;
        for (int i = 0; i < NS; i++) begin pv[i] = 1'b0; pd[i] = '0; end
        pp = '0;
        rst = 1'b1; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0; din = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk("R11 busy", {31'd0, busy}, 32'd0);
        chk("R11 dout", {24'd0, dout}, 32'd0);
        chk("R11 last_addr", {22'd0, last_addr}, 32'd0);
        chk("R11 last_data", {24'd0, last_data}, 32'd0);
        ce_n = 1'b0;

        // Baseline: fill page 3, then time the window (R4) and program cycle (R5)
        for (int i = 0; i < NS; i++) pulse_we(mk(3, i), DW'(i) ^ 8'hA5, 2, 1'b1);
        repeat (LW) @(negedge clk);
        chk("R4 busy before window end", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk("R4 busy at window end", {31'd0, busy}, 32'd1);
        repeat (PC - 1) @(negedge clk);
        chk("R5 busy last cycle", {31'd0, busy}, 32'd1);
        @(negedge clk);
        chk("R5 busy released", {31'd0, busy}, 32'd0);
        apply_prog();
        verify_page(3, "R5 baseline page");

        // Table walk: partial page in any order, one slot loaded twice (R3, R6)
        for (int i = 0; i < 10; i++)
            pulse_we(mk(3, int'(VEC[i][12:8])), VEC[i][7:0], 2 + (i % 3), 1'b1);
        settle();
        verify_page(3, "R6 partial page");

        // R3: page number follows the last accepted load
        pulse_we(mk(5, 1), 8'h11, 2, 1'b1);
        pulse_we(mk(5, 2), 8'h22, 2, 1'b1);
        pulse_we(mk(6, 4), 8'h44, 2, 1'b1);
        @(negedge clk);
        chk("R9 last_addr", {22'd0, last_addr}, {22'd0, mk(6, 4)});
        chk("R9 last_data", {24'd0, last_data}, 32'h44);
        settle();
        rd(mk(6, 1), v); chk("R3 page from last load slot1", {24'd0, v}, 32'h11);
        rd(mk(6, 2), v); chk("R3 page from last load slot2", {24'd0, v}, 32'h22);
        rd(mk(6, 4), v); chk("R3 page from last load slot4", {24'd0, v}, 32'h44);

        // R4: window restarted by each accepted pulse
        pulse_we(mk(7, 0), 8'hD0, 2, 1'b1);
        repeat (LW - 2) @(negedge clk);
        chk("R4 restart gap1", {31'd0, busy}, 32'd0);
        pulse_we(mk(7, 1), 8'hD1, 3, 1'b1);
        repeat (LW - 2) @(negedge clk);
        chk("R4 restart gap2", {31'd0, busy}, 32'd0);
        pulse_we(mk(7, 2), 8'hD2, 2, 1'b1);
        repeat (LW) @(negedge clk);
        chk("R4 restart before end", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk("R4 restart end", {31'd0, busy}, 32'd1);
        repeat (PC + 3) @(negedge clk);
        apply_prog();
        rd(mk(7, 1), v); chk("R4 restart data", {24'd0, v}, 32'hD1);

        // R7: short pulse has no effect
        keep = last_data;
        pulse_we(mk(3, 9), 8'h3C, 1, 1'b0);
        repeat (LW + 4) @(negedge clk);
        chk("R7 no program", {31'd0, busy}, 32'd0);
        chk("R7 last_data kept", {24'd0, last_data}, {24'd0, keep});
        rd(mk(3, 9), v); chk("R7 array kept", {24'd0, v}, {24'd0, mdl[mk(3, 9)]});

        // R1: output enable low blocks, and cuts a pulse
        @(negedge clk);
        addr = mk(3, 10); din = 8'hEE; oe_n = 1'b0; we_n = 1'b0;
        repeat (4) @(negedge clk);
        we_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        we_n = 1'b0;
        repeat (3) @(negedge clk);
        oe_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1; oe_n = 1'b1;
        repeat (LW + 4) @(negedge clk);
        chk("R1 no program", {31'd0, busy}, 32'd0);
        chk("R1 last_data kept", {24'd0, last_data}, {24'd0, keep});
        rd(mk(3, 10), v); chk("R1 array kept", {24'd0, v}, {24'd0, mdl[mk(3, 10)]});

        // R2: chip-enable driven pulse; address at later fall, data at earlier rise
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b0; addr = mk(3, 20); din = 8'h11;
        @(negedge clk);
        addr = mk(3, 21); ce_n = 1'b0;
        @(negedge clk);
        din = 8'h77;
        @(negedge clk);
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b0;
        chk("R2 address at later fall", {22'd0, last_addr}, {22'd0, mk(3, 21)});
        chk("R2 data at earlier rise", {24'd0, last_data}, 32'h77);
        pd[21] = 8'h77; pv[21] = 1'b1; pp = PGW'(3);
        settle();
        rd(mk(3, 21), v); chk("R2 stored", {24'd0, v}, 32'h77);
        rd(mk(3, 20), v); chk("R2 first address untouched", {24'd0, v}, {24'd0, mdl[mk(3, 20)]});

        // R8: strobes while busy are ignored
        pulse_we(mk(3, 30), 8'h42, 2, 1'b1);
        repeat (LW + 1) @(negedge clk);
        chk("R8 busy", {31'd0, busy}, 32'd1);
        pulse_we(mk(3, 31), 8'h99, 3, 1'b0);
        pulse_we(mk(3, 29), 8'h55, PC, 1'b0);
        repeat (LW + 4) @(negedge clk);
        chk("R8 no second program", {31'd0, busy}, 32'd0);
        chk("R8 last_data", {24'd0, last_data}, 32'h42);
        apply_prog();
        rd(mk(3, 30), v); chk("R8 accepted byte", {24'd0, v}, 32'h42);
        rd(mk(3, 31), v); chk("R8 busy strobe ignored", {24'd0, v}, {24'd0, mdl[mk(3, 31)]});
        rd(mk(3, 29), v); chk("R8 spanning strobe ignored", {24'd0, v}, {24'd0, mdl[mk(3, 29)]});
        pulse_we(mk(3, 0), 8'hC3, 2, 1'b1);
        settle();
        verify_page(3, "R8 flags cleared");

        // R10: read latency and hold
        rd(mk(3, 0), v);
        chk("R10 read", {24'd0, v}, 32'hC3);
        @(negedge clk);
        addr = mk(3, 1);
        @(negedge clk);
        chk("R10 dout held", {24'd0, dout}, 32'hC3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule